// File: doc/BRIEF.md
# Sectored Cache Tag Logic

This block holds the tags and per-sector state for a unified, 8-way set-associative cache. Each line has one tag and two 32-byte sectors. Each sector has its own valid bit and its own dirty bit. A lookup gets one of three answers. A sector hit means the tag matches and the addressed sector is valid. A sector miss means the tag matches but the addressed sector is not valid. A full-line miss means no way in the set holds the tag. On either kind of miss the block asks for exactly one sector to be filled: the one the address selects.

On a full-line miss, a tree pseudo-LRU chooses the victim way. The new tag replaces the old one and both sector valid bits start cleared. Every dirty sector of the evicted line is reported for write-back. A fill-complete port marks a sector valid once its data has arrived. An invalidate port drops a line by address. Each write lookup carries a flag that selects the write policy for the block it touches. With write-back selected, a write that hits a sector marks that sector dirty.

Top module: `sct_tag_top`

## Requirements
- R1: After a synchronous active-low reset, no line is allocated. The first lookup to any set is a full-line miss. While no result is due, `rs_valid`, `fill_req` and `wb_req` are low.
- R2: The address fields are decoded as follows: bits 4:0 are the byte offset, which is ignored; bit 5 selects the sector (0 or 1); the next log2(SETS) bits select the set; the remaining upper bits form the tag. The result of a lookup appears on the outputs on the clock edge after the one that samples `lk_valid`.
- R3: On a tag match where the addressed sector is valid, the block reports a sector hit. `rs_hit=1`, `rs_tag_match=1`, `fill_req=0`, `rs_way` is the matching way, and `rs_sec_valid` shows both sector valid bits (bit n is sector n).
- R4: On a tag match where the addressed sector is invalid, the block reports a sector miss. `rs_hit=0`, `rs_tag_match=1`, `rs_full_miss=0`, and `fill_req=1`. `fill_addr` is the lookup address with bits 4:0 cleared. The tag and the other sector's state are kept.
- R5: When no way matches, the block reports a full-line miss. `rs_full_miss=1`, `rs_sec_valid=0`, `fill_req=1` for the addressed sector, and `rs_way` is the victim. The victim gets the new tag with both sectors invalid and clean. A tag is never held by two ways of one set.
- R6: Each set keeps a 7-node pseudo-LRU tree. After reset every node is 0, and a 0 node points at its lower half. The victim is found by following the nodes from the root. Any tag match (sector hit or sector miss) and every allocation turn each node on the accessed way's path to point away from that way. In a fresh set, distinct full-line misses therefore allocate ways 0, 4, 2, 6, 1, 5, 3, 7, and then way 0 again.
- R7: A fill-complete (`fl_valid` with set, way and sector) sets that sector's valid bit. A later lookup of that sector hits.
- R8: A write lookup that gets a sector hit with `lk_wback=1` marks that sector dirty. With `lk_wback=0` the sector stays clean.
- R9: On a full-line miss, `wb_req` bit n is set exactly when sector n of the victim was dirty. `wb_addr` is the victim's line address (old tag and set, bits 5:0 zero).
- R10: An invalidate whose tag matches a line in the addressed set clears that line's tag valid, sector valid and dirty bits. An invalidate with no match changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_write | input | 1 | Lookup is a write |
| lk_wback | input | 1 | Write policy of the block: 1 write-back, 0 write-through |
| fl_valid | input | 1 | Sector fill completed |
| fl_set | input | IDX_W | Set of the completed fill |
| fl_way | input | WAY_W | Way of the completed fill |
| fl_sector | input | 1 | Sector of the completed fill |
| iv_valid | input | 1 | Invalidate request |
| iv_addr | input | ADDR_W | Address of the line to invalidate |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Sector hit |
| rs_tag_match | output | 1 | Tag matched in some way |
| rs_full_miss | output | 1 | No way matched; victim allocated |
| rs_way | output | WAY_W | Matching way or victim way |
| rs_sec_valid | output | 2 | Sector valid bits of that way before the lookup |
| fill_req | output | 1 | Request to fill one sector |
| fill_addr | output | ADDR_W | Sector-aligned fill address |
| wb_req | output | 2 | Victim sectors needing write-back |
| wb_addr | output | ADDR_W | Victim line address |

## Verification
Every lookup result, fill request and write-back request arrives exactly one clock edge after the edge that samples `lk_valid`. Fills and invalidates take effect on the edge that samples them, so the lookup that follows them sees the new state.

The driver task applies one request at a falling edge and pushes the expected result into a queue. The monitor pops that result at the next falling edge, which is half a cycle after the register edge. Any result that arrives with no entry queued is counted as an error. Pseudo-LRU order, dirty marking and invalidation are all observed through later lookups at the ports.

// File: rtl/sct_pkg.sv
// Package: shared constants and types for the sectored tag logic.
// Assumes two sectors per line; the sector count is structural, not a knob.
package sct_pkg;
    localparam int SECTORS = 2;
    typedef logic [SECTORS-1:0] sec_bits_t;
endpackage

// File: rtl/sct_tag_match.sv
// Module: compares one address tag against all ways of a set.
// Assumes at most one way holds a given valid tag (checked here).
module sct_tag_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 22,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
    input  logic [WAYS-1:0]             set_tvld,
    input  logic [TAG_W-1:0]            probe_tag,
    output logic                        any_hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] hit_vec;

    // Per-way equality, gated by the line's tag-valid bit.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_tvld[w] && (set_tags[w] == probe_tag);
    end

    // Encode the matching way; index 0 when nothing matches.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit = |hit_vec;

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R5
endmodule

// File: rtl/sct_plru.sv
// Module: tree pseudo-LRU for one set, purely combinational.
// Assumes WAYS is a power of two; node n has children 2n+1 and 2n+2,
// and a 0 node steers the victim search toward the lower half.
module sct_plru #(
    parameter int WAYS = 8,
    localparam int LVL = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] tree_in,
    input  logic [LVL-1:0]  acc_way,
    output logic [WAYS-2:0] tree_out,
    output logic [LVL-1:0]  victim
);
    // Walk from the root following the node bits to find the victim.
    always_comb begin
        int node;
        node = 0;
        victim = '0;
        for (int l = 0; l < LVL; l++) begin
            victim[LVL-1-l] = tree_in[node];
            node = 2 * node + 1 + int'(tree_in[node]);
        end
    end

    // Walk the accessed way's path, pointing each node away from it.
    always_comb begin
        int node;
        node = 0;
        tree_out = tree_in;
        for (int l = 0; l < LVL; l++) begin
            tree_out[node] = ~acc_way[LVL-1-l];
            node = 2 * node + 1 + int'(acc_way[LVL-1-l]);
        end
    end
endmodule

// File: rtl/sct_tag_top.sv
// Module: tag, sector-valid, dirty and replacement state of a sectored
// 8-way cache. Assumes fills and invalidates name lines that the caller
// obtained from earlier lookup results; results are registered one cycle.
module sct_tag_top #(
    parameter int ADDR_W       = 32,
    parameter int SETS         = 16,
    parameter int WAYS         = 8,
    parameter int SECTOR_BYTES = 32,
    localparam int OFF_W = $clog2(SECTOR_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_write,
    input  logic              lk_wback,
    input  logic              fl_valid,
    input  logic [IDX_W-1:0]  fl_set,
    input  logic [WAY_W-1:0]  fl_way,
    input  logic              fl_sector,
    input  logic              iv_valid,
    input  logic [ADDR_W-1:0] iv_addr,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_tag_match,
    output logic              rs_full_miss,
    output logic [WAY_W-1:0]  rs_way,
    output logic [1:0]        rs_sec_valid,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [1:0]        wb_req,
    output logic [ADDR_W-1:0] wb_addr
);
    import sct_pkg::*;

    localparam int SEC_BIT = OFF_W;
    localparam int IDX_LO  = OFF_W + 1;

    logic [WAYS-1:0][TAG_W-1:0]   tag_q  [SETS];
    logic [WAYS-1:0]              tv_q   [SETS];
    sec_bits_t [WAYS-1:0]         sv_q   [SETS];
    sec_bits_t [WAYS-1:0]         dt_q   [SETS];
    logic [WAYS-2:0]              plru_q [SETS];

    logic [IDX_W-1:0] lk_set, iv_set;
    logic [TAG_W-1:0] lk_tag, iv_tag;
    logic             lk_sec;
    logic             lk_hit, iv_hit;
    logic [WAY_W-1:0] lk_hway, iv_hway, victim, acc_way;
    logic [WAYS-2:0]  tree_nx;
    sec_bits_t        way_sv;

    // Split both request addresses into tag, set and sector fields.
    assign lk_set = lk_addr[IDX_LO +: IDX_W];
    assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
    assign lk_sec = lk_addr[SEC_BIT];
    assign iv_set = iv_addr[IDX_LO +: IDX_W];
    assign iv_tag = iv_addr[ADDR_W-1 -: TAG_W];

    sct_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n),
        .set_tags(tag_q[lk_set]), .set_tvld(tv_q[lk_set]),
        .probe_tag(lk_tag), .any_hit(lk_hit), .hit_way(lk_hway)
    );

    sct_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_iv_match (
        .clk(clk), .rst_n(rst_n),
        .set_tags(tag_q[iv_set]), .set_tvld(tv_q[iv_set]),
        .probe_tag(iv_tag), .any_hit(iv_hit), .hit_way(iv_hway)
    );

    // The touched way is the match on a tag hit, else the victim.
    assign acc_way = lk_hit ? lk_hway : victim;
    assign way_sv  = sv_q[lk_set][lk_hway];

    sct_plru #(.WAYS(WAYS)) u_plru (
        .tree_in(plru_q[lk_set]), .acc_way(acc_way),
        .tree_out(tree_nx), .victim(victim)
    );

    // Lookup results, state updates from lookup, fill and invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid     <= 1'b0;
            rs_hit       <= 1'b0;
            rs_tag_match <= 1'b0;
            rs_full_miss <= 1'b0;
            rs_way       <= '0;
            rs_sec_valid <= '0;
            fill_req     <= 1'b0;
            fill_addr    <= '0;
            wb_req       <= '0;
            wb_addr      <= '0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]  <= '0;
                tv_q[s]   <= '0;
                sv_q[s]   <= '0;
                dt_q[s]   <= '0;
                plru_q[s] <= '0;
            end
        end else begin
            rs_valid <= lk_valid;
            fill_req <= 1'b0;
            wb_req   <= '0;
            if (lk_valid) begin
                fill_addr      <= {lk_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                plru_q[lk_set] <= tree_nx;
                rs_way         <= acc_way;
                if (lk_hit) begin
                    rs_tag_match <= 1'b1;
                    rs_full_miss <= 1'b0;
                    rs_sec_valid <= way_sv;
                    rs_hit       <= way_sv[lk_sec];
                    fill_req     <= !way_sv[lk_sec];
                    if (way_sv[lk_sec] && lk_write && lk_wback)
                        dt_q[lk_set][lk_hway][lk_sec] <= 1'b1;
                end else begin
                    rs_tag_match           <= 1'b0;
                    rs_full_miss           <= 1'b1;
                    rs_hit                 <= 1'b0;
                    rs_sec_valid           <= '0;
                    fill_req               <= 1'b1;
                    wb_req                 <= dt_q[lk_set][victim];
                    wb_addr                <= {tag_q[lk_set][victim], lk_set, {(OFF_W+1){1'b0}}};
                    tag_q[lk_set][victim]  <= lk_tag;
                    tv_q[lk_set][victim]   <= 1'b1;
                    sv_q[lk_set][victim]   <= '0;
                    dt_q[lk_set][victim]   <= '0;
                end
            end
            if (fl_valid)
                sv_q[fl_set][fl_way][fl_sector] <= 1'b1;
            if (iv_valid && iv_hit) begin
                tv_q[iv_set][iv_hway] <= 1'b0;
                sv_q[iv_set][iv_hway] <= '0;
                dt_q[iv_set][iv_hway] <= '0;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rs_valid |-> (!fill_req && wb_req == 2'b00)); // R1
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rs_valid); // R2
    AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (rs_valid && rs_hit) |-> (!fill_req && rs_tag_match)); // R3
    AST_FILL_SECTOR: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> (!fill_req || fill_addr[SEC_BIT] == $past(lk_addr[SEC_BIT]))); // R4
    AST_FULL_MISS_FILL: assert property (@(posedge clk) disable iff (!rst_n) (rs_valid && rs_full_miss) |-> (fill_req && !rs_tag_match && rs_sec_valid == 2'b00)); // R5
    AST_WB_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n) (wb_req != 2'b00) |-> (rs_valid && rs_full_miss)); // R9
endmodule

// File: tb/sct_tag_top_tb_top.sv
// Bench: scoreboard for the sectored tag logic; a driver queues expected
// lookup results, a monitor compares them half a cycle after they appear.
module sct_tag_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write, lk_wback;
    logic [31:0] lk_addr;
    logic        fl_valid, fl_sector;
    logic [3:0]  fl_set;
    logic [2:0]  fl_way;
    logic        iv_valid;
    logic [31:0] iv_addr;
    logic        rs_valid, rs_hit, rs_tag_match, rs_full_miss, fill_req;
    logic [2:0]  rs_way;
    logic [1:0]  rs_sec_valid, wb_req;
    logic [31:0] fill_addr, wb_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       req;
        logic        hit, tm, fm, fr;
        logic [2:0]  way;
        logic [1:0]  sv, wr;
        logic [31:0] fa, wa;
    } exp_t;
    exp_t q[$];

    sct_tag_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write), .lk_wback(lk_wback),
        .fl_valid(fl_valid), .fl_set(fl_set), .fl_way(fl_way), .fl_sector(fl_sector),
        .iv_valid(iv_valid), .iv_addr(iv_addr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_tag_match(rs_tag_match),
        .rs_full_miss(rs_full_miss), .rs_way(rs_way), .rs_sec_valid(rs_sec_valid),
        .fill_req(fill_req), .fill_addr(fill_addr), .wb_req(wb_req), .wb_addr(wb_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(int tag, int set, int sec, int off);
        return {tag[21:0], set[3:0], sec[0], off[4:0]};
    endfunction

    task automatic lookup(input logic [31:0] a, input logic wr, input logic wb,
                          input string req, input logic hit, input logic tm,
                          input logic fm, input int way, input logic [1:0] sv,
                          input logic fr, input logic [1:0] wrq, input logic [31:0] wa);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_write = wr; lk_wback = wb;
        e.req = req; e.hit = hit; e.tm = tm; e.fm = fm; e.way = way[2:0];
        e.sv = sv; e.fr = fr; e.fa = {a[31:5], 5'b0}; e.wr = wrq; e.wa = wa;
        q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic fill(input int set, input int way, input int sec);
        @(negedge clk);
        fl_valid = 1'b1; fl_set = set[3:0]; fl_way = way[2:0]; fl_sector = sec[0];
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic inval(input logic [31:0] a);
        @(negedge clk);
        iv_valid = 1'b1; iv_addr = a;
        @(negedge clk);
        iv_valid = 1'b0;
    endtask

    // Monitor: pop and compare each result half a cycle after it is registered.
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R2: result with no lookup pending, actual rs_valid=%b expected 0", rs_valid);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rs_hit !== e.hit || rs_tag_match !== e.tm || rs_full_miss !== e.fm ||
                    rs_way !== e.way || rs_sec_valid !== e.sv || fill_req !== e.fr ||
                    (e.fr && fill_addr !== e.fa) || wb_req !== e.wr ||
                    (e.wr != 2'b00 && wb_addr !== e.wa)) begin
                    errors++;
                    $display("FAIL %s: actual hit=%b tm=%b fm=%b way=%0d sv=%b fr=%b fa=%h wr=%b wa=%h expected hit=%b tm=%b fm=%b way=%0d sv=%b fr=%b fa=%h wr=%b wa=%h",
                             e.req, rs_hit, rs_tag_match, rs_full_miss, rs_way, rs_sec_valid,
                             fill_req, fill_addr, wb_req, wb_addr, e.hit, e.tm, e.fm, e.way,
                             e.sv, e.fr, e.fa, e.wr, e.wa);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0; lk_write = 1'b0; lk_wback = 1'b0;
        fl_valid = 1'b0; fl_set = '0; fl_way = '0; fl_sector = 1'b0;
        iv_valid = 1'b0; iv_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        checks++;
        if (rs_valid !== 1'b0 || fill_req !== 1'b0 || wb_req !== 2'b00) begin
            errors++;
            $display("FAIL R1: actual rs_valid=%b fill_req=%b wb_req=%b expected 0 0 00",
                     rs_valid, fill_req, wb_req);
        end
        // R1 R5: first lookup after reset is a full miss into way 0
        lookup(mk(1,3,0,0), 0, 0, "R1 R5", 0,0,1, 0, 2'b00, 1, 2'b00, 0);
        // R7 R3 R2: fill sector 0, then hit with a nonzero offset
        fill(3, 0, 0);
        lookup(mk(1,3,0,7), 0, 0, "R7 R3 R2", 1,1,0, 0, 2'b01, 0, 2'b00, 0);
        // R4: same tag, other sector invalid -> sector miss, fill only sector 1
        lookup(mk(1,3,1,0), 0, 0, "R4", 0,1,0, 0, 2'b01, 1, 2'b00, 0);
        fill(3, 0, 1);
        // R8: write-back write dirties sector 1, write-through write leaves sector 0 clean
        lookup(mk(1,3,1,4), 1, 1, "R8 R3", 1,1,0, 0, 2'b11, 0, 2'b00, 0);
        lookup(mk(1,3,0,4), 1, 0, "R8 R3", 1,1,0, 0, 2'b11, 0, 2'b00, 0);
        // R6: victims follow the tree order 4,2,6,1,5,3,7
        lookup(mk(2,3,0,0), 0, 0, "R6", 0,0,1, 4, 2'b00, 1, 2'b00, 0);
        lookup(mk(3,3,0,0), 0, 0, "R6", 0,0,1, 2, 2'b00, 1, 2'b00, 0);
        lookup(mk(4,3,0,0), 0, 0, "R6", 0,0,1, 6, 2'b00, 1, 2'b00, 0);
        lookup(mk(5,3,0,0), 0, 0, "R6", 0,0,1, 1, 2'b00, 1, 2'b00, 0);
        lookup(mk(6,3,0,0), 0, 0, "R6", 0,0,1, 5, 2'b00, 1, 2'b00, 0);
        lookup(mk(7,3,0,0), 0, 0, "R6", 0,0,1, 3, 2'b00, 1, 2'b00, 0);
        lookup(mk(8,3,0,0), 0, 0, "R6", 0,0,1, 7, 2'b00, 1, 2'b00, 0);
        // R9 R6: way 0 evicted again; only sector 1 was dirty
        lookup(mk(9,3,0,0), 0, 0, "R9 R6", 0,0,1, 0, 2'b00, 1, 2'b10, mk(1,3,0,0));
        // R10: non-matching invalidate has no effect; tag 3 still matches in way 2
        inval(mk(99,3,0,0));
        lookup(mk(3,3,1,0), 0, 0, "R10 R4", 0,1,0, 2, 2'b00, 1, 2'b00, 0);
        // R10: invalidating tag 2 turns its next lookup into a full miss (victim way 4)
        inval(mk(2,3,0,0));
        lookup(mk(2,3,0,0), 0, 0, "R10 R5", 0,0,1, 4, 2'b00, 1, 2'b00, 0);
        // R2: another set is independent of set 3
        lookup(mk(1,4,1,0), 0, 0, "R2 R5", 0,0,1, 0, 2'b00, 1, 2'b00, 0);
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2: actual %0d results missing, expected 0", q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule